// File: doc/BRIEF.md
# Return Address Stack

This block predicts function-return targets for an instruction fetch unit. When a call is seen, the fetch logic strobes the push input with the address the call will return to; when a return is seen, it reads the top-of-stack output as the predicted target in that same cycle and strobes the pop input. The block keeps the most recent return addresses in last-in-first-out order.

Storage is a ring of entries addressed by a write pointer. A push is never refused. When the call depth exceeds the entry count, the pointer wraps and the oldest return address is overwritten and lost, while the most recent ones stay correct. An occupancy counter saturates at the entry count and drives the valid flag. A pop on an empty stack is ignored. Raising push and pop in the same cycle replaces the top entry without moving the pointer, which matches a return followed at once by a call.

Top module: `ret_addr_stack`

## Requirements
- R1: While the synchronous active-high reset is high at a clock edge, the stack empties: after that edge `top_valid_o` is 0 and `top_addr_o` is 0, whatever was stored before.
- R2: A push with pop low makes `top_valid_o` 1 and `top_addr_o` equal to the pushed address in the cycle after the edge.
- R3: `top_addr_o` is combinational from the stored state, so it shows the value a pop consumes in the cycle that pop is requested; after a pop the entry pushed before it becomes the top (last in, first out).
- R4: With 16 entries (default), pushing more than 16 addresses is accepted every time; afterwards exactly the 16 most recent come back in reverse order of pushing, and the stack then reads empty.
- R5: A pop while the stack is empty (and push low) has no effect: `top_valid_o` stays 0, and a later push followed by a pop returns that pushed address and leaves the stack empty.
- R6: Push and pop in one cycle on a non-empty stack replace the top with the new address and keep the depth: the entry below it is still returned by the next pop.
- R7: Push and pop in one cycle on an empty stack act as a plain push: the stack then holds exactly that one address.
- R8: In a cycle with neither push nor pop, `top_valid_o` and `top_addr_o` keep their values.
- R9: `top_addr_o` reads 0 whenever `top_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Store `ret_addr_i` as the new top |
| pop_i | input | 1 | Remove the current top |
| ret_addr_i | input | ADDR_W (32) | Return address to store on a push |
| top_addr_o | output | ADDR_W (32) | Current top entry, 0 when empty |
| top_valid_o | output | 1 | High when at least one entry is held |

## Verification
The bench drives runs of calls deeper than the capacity, since a design that stalled, saturated the pointer or lost the newest entry instead of the oldest would return wrong targets on the way back down. It pops an empty stack and then pushes, catching a pointer that underflows and leaves the next push misplaced or the valid flag stuck high. Push and pop together are tried on both a full-ish and an empty stack, where a design that moved the pointer would either lose the entry below or leave a stale entry behind. Reads are also checked in the same cycle as a pop request, which exposes a top output that lags by a register.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Operation applied to the stack in one cycle, after strobe decoding.
  typedef enum logic [1:0] {
    RAS_IDLE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2,
    RAS_SWAP = 2'd3
  } ras_op_e;

endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
  import ras_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    nonempty_i,
  output ras_op_e op_o
);

  // A pop on an empty stack is dropped; push+pop on an empty stack is a push.
  always_comb begin
    op_o = RAS_IDLE;
    if (push_i && pop_i && nonempty_i) begin
      op_o = RAS_SWAP;
    end else if (push_i) begin
      op_o = RAS_PUSH;
    end else if (pop_i && nonempty_i) begin
      op_o = RAS_POP;
    end
  end

endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ras_op_e                    op_i,
  output logic                       wr_en_o,
  output logic [$clog2(DEPTH)-1:0]   wr_idx_o,
  output logic [$clog2(DEPTH)-1:0]   rd_idx_o,
  output logic                       nonempty_o
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] ptr_q;   // next free slot
  logic [CNT_W-1:0] cnt_q;   // saturating occupancy
  logic [IDX_W-1:0] ptr_inc;
  logic [IDX_W-1:0] ptr_dec;

  // Explicit wrap so that a non-power-of-two depth still forms a ring.
  always_comb begin
    ptr_inc = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    ptr_dec = (ptr_q == '0) ? LAST_IDX : ptr_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      case (op_i)
        RAS_PUSH: begin
          ptr_q <= ptr_inc;
          if (cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
        end
        RAS_POP: begin
          ptr_q <= ptr_dec;
          cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          ptr_q <= ptr_q;
          cnt_q <= cnt_q;
        end
      endcase
    end
  end

  assign wr_en_o    = (op_i == RAS_PUSH) || (op_i == RAS_SWAP);
  assign wr_idx_o   = (op_i == RAS_SWAP) ? ptr_dec : ptr_q;
  assign rd_idx_o   = ptr_dec;
  assign nonempty_o = (cnt_q != '0);

endmodule

// File: rtl/ras_entry_store.sv
module ras_entry_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       wr_en_i,
  input  logic [$clog2(DEPTH)-1:0]   wr_idx_i,
  input  logic [ADDR_W-1:0]          wr_data_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
  output logic [ADDR_W-1:0]          rd_data_o
);

  // One write port, one asynchronous read port: maps to distributed RAM.
  logic [ADDR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_idx_i];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  output logic [ADDR_W-1:0] top_addr_o,
  output logic              top_valid_o
);

  localparam int IDX_W = $clog2(DEPTH);

  ras_op_e          op;
  logic             nonempty;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [ADDR_W-1:0] rd_data;

  ras_op_decode u_dec (
    .push_i     (push_i),
    .pop_i      (pop_i),
    .nonempty_i (nonempty),
    .op_o       (op)
  );

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .rd_idx_o   (rd_idx),
    .nonempty_o (nonempty)
  );

  ras_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (ret_addr_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  assign top_valid_o = nonempty;
  assign top_addr_o  = nonempty ? rd_data : '0;

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              push_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] ret_addr_i,
  input logic [ADDR_W-1:0] top_addr_o,
  input logic              top_valid_o
);

  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (!top_valid_o && top_addr_o == '0));

  assert_push_on_top_R2: assert property (@(posedge clk) disable iff (rst)
    push_i |=> (top_valid_o && top_addr_o == $past(ret_addr_i)));

  assert_empty_pop_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (!top_valid_o && pop_i && !push_i) |=> !top_valid_o);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i) |=> ($stable(top_valid_o) && $stable(top_addr_o)));

  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (!top_valid_o && !push_i) |=> (top_valid_o || top_addr_o == '0));

endmodule

bind ret_addr_stack ras_checker #(.ADDR_W(ADDR_W)) u_ras_checker (
  .clk         (clk),
  .rst         (rst),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .ret_addr_i  (ret_addr_i),
  .top_addr_o  (top_addr_o),
  .top_valid_o (top_valid_o)
);

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              push_i = 1'b0;
  logic              pop_i = 1'b0;
  logic [ADDR_W-1:0] ret_addr_i = '0;
  logic [ADDR_W-1:0] top_addr_o;
  logic              top_valid_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic              v;
    logic [ADDR_W-1:0] a;
    string             req;
  } exp_t;

  exp_t              exp_q[$];
  logic [ADDR_W-1:0] model[$];   // reference stack, back = top
  bit                done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ret_addr_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk (clk), .rst (rst), .push_i (push_i), .pop_i (pop_i),
    .ret_addr_i (ret_addr_i), .top_addr_o (top_addr_o), .top_valid_o (top_valid_o)
  );

  function automatic void check(input string req, input logic ev, input logic [ADDR_W-1:0] ea);
    checks++;
    if (top_valid_o !== ev || top_addr_o !== ea) begin
      errors++;
      $display("FAIL %s: valid=%0b top=%h expected valid=%0b top=%h",
               req, top_valid_o, top_addr_o, ev, ea);
    end
  endfunction

  function automatic exp_t model_expect(input string req);
    exp_t e;
    e.v   = (model.size() > 0);
    e.a   = e.v ? model[$] : '0;
    e.req = req;
    return e;
  endfunction

  // Driver: apply one cycle of strobes, update the model, queue the expectation.
  task automatic step(input logic ps, input logic pp, input logic [ADDR_W-1:0] addr,
                      input string req);
    @(negedge clk);
    push_i = ps; pop_i = pp; ret_addr_i = addr;
    if (pp) begin
      #1;
      check({req, " same-cycle top (R3)"}, model.size() > 0,
            (model.size() > 0) ? model[$] : '0);
    end
    @(posedge clk);
    if (ps && pp && model.size() > 0) begin
      model[model.size()-1] = addr;
    end else if (ps) begin
      model.push_back(addr);
      if (model.size() > DEPTH) void'(model.pop_front());
    end else if (pp && model.size() > 0) begin
      void'(model.pop_back());
    end
    exp_q.push_back(model_expect(req));
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; push_i = 1'b0; pop_i = 1'b0;
    @(posedge clk);
    @(posedge clk);
    model.delete();
    @(negedge clk);
    rst = 1'b0;
    check(req, 1'b0, '0);
  endtask

  // Monitor: compare the queued expectations away from the clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, e.v, e.a);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset empty");
    step(1'b0, 1'b0, 32'h0, "R8 idle when empty");

    // R2 / R3: basic push then LIFO pops
    step(1'b1, 1'b0, 32'h0000_1000, "R2 push a");
    step(1'b1, 1'b0, 32'h0000_2004, "R2 push b");
    step(1'b0, 1'b0, 32'hDEAD_BEEF, "R8 idle holds top");
    step(1'b1, 1'b0, 32'h0000_3008, "R2 push c");
    step(1'b0, 1'b1, 32'h0, "R3 pop c");
    step(1'b0, 1'b1, 32'h0, "R3 pop b");
    step(1'b0, 1'b1, 32'h0, "R3 pop a");

    // R5: underflow is ignored
    step(1'b0, 1'b1, 32'h0, "R5 pop empty");
    step(1'b0, 1'b1, 32'h0, "R5 pop empty again");
    step(1'b1, 1'b0, 32'h0000_4440, "R5 push after underflow");
    step(1'b0, 1'b1, 32'h0, "R5 pop after underflow");
    step(1'b0, 1'b0, 32'h0, "R9 empty reads zero");

    // R6: replace top in place
    step(1'b1, 1'b0, 32'h0000_5000, "R6 push base");
    step(1'b1, 1'b0, 32'h0000_5100, "R6 push old top");
    step(1'b1, 1'b1, 32'h0000_5200, "R6 swap top");
    step(1'b0, 1'b1, 32'h0, "R6 pop new top");
    step(1'b0, 1'b1, 32'h0, "R6 pop base survives");

    // R7: push+pop on empty behaves as push
    step(1'b1, 1'b1, 32'h0000_6000, "R7 swap on empty");
    step(1'b0, 1'b1, 32'h0, "R7 pop single");
    step(1'b0, 1'b0, 32'h0, "R7 empty after single");

    // R4: overflow wraps and drops the oldest
    for (int i = 0; i < DEPTH + 5; i++) begin
      step(1'b1, 1'b0, 32'hA000_0000 + 32'(i * 4), "R4 deep push");
    end
    for (int i = 0; i < DEPTH + 2; i++) begin
      step(1'b0, 1'b1, 32'h0, "R4 unwind");
    end

    // R4 exactly full, then one more unwind from full depth
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 32'hB000_0000 + 32'(i), "R4 fill exact");
    end
    step(1'b1, 1'b1, 32'hC0DE_0000, "R6 swap when full");
    for (int i = 0; i < DEPTH + 1; i++) begin
      step(1'b0, 1'b1, 32'h0, "R4 unwind full");
    end

    // R1: reset with live content
    step(1'b1, 1'b0, 32'h0000_7777, "R2 push before reset");
    step(1'b1, 1'b0, 32'h0000_8888, "R2 push before reset");
    do_reset("R1 reset discards content");
    step(1'b0, 1'b1, 32'h0, "R1 pop after reset");

    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    @(posedge clk);
    #10;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule